// File: doc/BRIEF.md
# Two-Pass Resize Input Sequencer

This block sits in front of a line-based image resizer and chooses where the resizer takes its pixels from. There are two candidate sources: a live pixel stream from the upstream capture pipeline, and a stream read back from memory. A resize whose ratio is too large for one pass runs in two passes. The first pass resizes live pixels and the result is written to memory. The second pass reads that result back and resizes it again. The sequencer will not accept a new live frame while the second pass of the previous frame is still pending.

Two sources of late frames exist. The first is a live frame that starts while the resizer is busy with pass two. The second is a switch of the source select to live while a live frame is already in flight. In both cases the sequencer drops that frame and raises a sticky overflow flag. The flag stays set until software writes a clear pulse. It also appears at a fixed position in a shared event status word.

Pixels that are accepted go out to the resizer one cycle later, tagged with the stream they came from. The scaling arithmetic and the memory traffic are handled outside this block.

Top module: `rsz_pass_seq`

## Requirements
- R1: After reset, `live_ready` is 1, `rsz_valid` is 0 and `ovf_flag` is 0. Every bit of `evt_word` is 0.
- R2: With `cfg_src_live`=1 and the block idle, a `live_sof` starts pass one. That pixel and each later valid live pixel of pass one appear on `rsz_valid`/`rsz_sof`/`rsz_data` one cycle after input, with `rsz_from_mem`=0.
- R3: If `pass1_done` arrives while `cfg_two_pass`=0, `live_ready` returns to 1 in the next cycle.
- R4: If `pass1_done` arrives while `cfg_two_pass`=1, `live_ready` stays 0. The next `mem_sof` then starts pass two, and its pixels go out one cycle later with `rsz_from_mem`=1. `live_ready` returns to 1 one cycle after `pass2_done`.
- R5: A `live_sof` that arrives while pass two is pending or running sets `ovf_flag` in the next cycle. None of its pixels reach the resizer.
- R6: "Active" means a valid live pixel has been seen since the last `live_sof`, and the `live_sof` pixel itself counts. If `cfg_src_live` rises 0→1 while the block is idle and live data is active, with no `live_sof` in that same cycle, `ovf_flag` is set next cycle. Live pixels are then discarded until the next `live_sof`, which is accepted as a new pass one.
- R7: If `cfg_src_live` rises in the same cycle as a `live_sof`, the overflow flag is not set and that frame is accepted.
- R8: `ovf_flag` is sticky. A pulse on `ovf_clr` clears it in the next cycle. When a set and a clear fall in the same cycle, the set takes effect.
- R9: `evt_word` carries `ovf_flag` at bit 24 (`OVF_BIT`). All other bits of `evt_word` are 0.
- R10: With `cfg_src_live`=0 and the block idle, a `mem_sof` starts a single memory-sourced pass that is forwarded with `rsz_from_mem`=1 and ends on `pass2_done`.
- R11: While idle, live pixels are not forwarded if they arrive without a `live_sof`, or if the select is memory (`cfg_src_live`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_live | input | 1 | Source select: 1 live stream, 0 memory stream |
| cfg_two_pass | input | 1 | 1 when the ratio needs two passes |
| ovf_clr | input | 1 | Write-one pulse clearing the overflow flag |
| live_sof | input | 1 | Live stream frame start (with first pixel) |
| live_valid | input | 1 | Live stream pixel valid |
| live_data | input | DW | Live stream pixel |
| mem_sof | input | 1 | Memory stream frame start |
| mem_valid | input | 1 | Memory stream pixel valid |
| mem_data | input | DW | Memory stream pixel |
| pass1_done | input | 1 | Resizer finished pass one |
| pass2_done | input | 1 | Resizer finished the memory pass |
| rsz_sof | output | 1 | Frame start toward the resizer |
| rsz_valid | output | 1 | Pixel valid toward the resizer |
| rsz_data | output | DW | Pixel toward the resizer |
| rsz_from_mem | output | 1 | Forwarded pixel came from memory |
| live_ready | output | 1 | Idle and able to take a new frame |
| ovf_flag | output | 1 | Sticky overflow flag |
| evt_word | output | STAT_W | Event status word holding the flag |

## Verification
Some properties are checked on every cycle. The flag never falls without a clear pulse, and a live frame start during a pending or running second pass always raises it. Forwarded pixels always trace back to a valid pixel on the source they are tagged with, and no live pixel leaks out while pass two is pending. The status word never has more than one bit set. Other behaviours only show up in the bench's scenarios. These are the drop-until-next-frame recovery after a late source switch, the acceptance of a switch that coincides with a frame start, the set-over-clear priority, and the exact forwarded pixel values across the sweep of frame lengths and pass modes.

// File: rtl/rsz_seq_pkg.sv
package rsz_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_P1   = 3'd1,
    ST_WAIT = 3'd2,
    ST_P2   = 3'd3,
    ST_DROP = 3'd4
  } seq_st_t;
endpackage

// File: rtl/rsz_seq_actmon.sv
module rsz_seq_actmon (
  input  logic clk,
  input  logic rst_n,
  input  logic src_live,
  input  logic live_sof,
  input  logic live_valid,
  output logic late_switch
);
  logic src_q;
  logic act_q;
  logic act_en;
  logic act_d;

  assign act_en = live_sof | live_valid;
  assign act_d  = live_sof ? live_valid : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      src_q <= src_live;
      if (act_en) begin
        act_q <= act_d;
      end
    end
  end

  // rising select with a live frame already in flight, not a fresh start
  assign late_switch = src_live & ~src_q & act_q & ~live_sof;
endmodule

// File: rtl/rsz_seq_fsm.sv
module rsz_seq_fsm
  import rsz_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    src_live,
  input  logic    two_pass,
  input  logic    late_switch,
  input  logic    live_sof,
  input  logic    mem_sof,
  input  logic    pass1_done,
  input  logic    pass2_done,
  output seq_st_t st,
  output logic    fwd_live,
  output logic    fwd_mem,
  output logic    ovf_set
);
  seq_st_t st_q;
  seq_st_t st_d;
  logic    sw_evt;
  logic    busy_evt;

  assign sw_evt   = late_switch & (st_q == ST_IDLE);
  assign busy_evt = live_sof & ((st_q == ST_WAIT) | (st_q == ST_P2));
  assign ovf_set  = sw_evt | busy_evt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (sw_evt)                    st_d = ST_DROP;
        else if (src_live & live_sof)  st_d = ST_P1;
        else if (~src_live & mem_sof)  st_d = ST_P2;
      end
      ST_P1:   if (pass1_done) st_d = two_pass ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (mem_sof)    st_d = ST_P2;
      ST_P2:   if (pass2_done) st_d = ST_IDLE;
      ST_DROP: if (live_sof)   st_d = src_live ? ST_P1 : ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    fwd_live = (st_q == ST_P1) | ((st_d == ST_P1) & live_sof);
    fwd_mem  = (st_q == ST_P2) | ((st_d == ST_P2) & mem_sof);
  end

  assign st = st_q;
endmodule

// File: rtl/rsz_seq_outreg.sv
module rsz_seq_outreg #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_live,
  input  logic          fwd_mem,
  input  logic          live_sof,
  input  logic          live_valid,
  input  logic [DW-1:0] live_data,
  input  logic          mem_sof,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          rsz_sof,
  output logic          rsz_valid,
  output logic [DW-1:0] rsz_data,
  output logic          rsz_from_mem
);
  logic          v_d;
  logic          s_d;
  logic [DW-1:0] d_d;
  logic          data_en;

  always_comb begin
    v_d = 1'b0;
    s_d = 1'b0;
    d_d = live_data;
    if (fwd_live) begin
      v_d = live_valid;
      s_d = live_sof & live_valid;
    end else if (fwd_mem) begin
      v_d = mem_valid;
      s_d = mem_sof & mem_valid;
      d_d = mem_data;
    end
  end

  assign data_en = v_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsz_valid    <= 1'b0;
      rsz_sof      <= 1'b0;
      rsz_from_mem <= 1'b0;
    end else begin
      rsz_valid <= v_d;
      rsz_sof   <= s_d;
      if (data_en) rsz_from_mem <= fwd_mem & ~fwd_live;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) rsz_data <= d_d;
  end
endmodule

// File: rtl/rsz_seq_flag.sv
module rsz_seq_flag #(
  parameter int STAT_W  = 32,
  parameter int OVF_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_set,
  input  logic              ovf_clr,
  output logic              ovf_flag,
  output logic [STAT_W-1:0] evt_word
);
  logic flag_q;
  logic flag_en;
  logic flag_d;

  assign flag_en = ovf_set | ovf_clr;
  assign flag_d  = ovf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  for (genvar g = 0; g < STAT_W; g++) begin : g_evt
    if (g == OVF_BIT) begin : g_hit
      assign evt_word[g] = flag_q;
    end else begin : g_zero
      assign evt_word[g] = 1'b0;
    end
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/rsz_pass_seq.sv
module rsz_pass_seq
  import rsz_seq_pkg::*;
#(
  parameter int DW      = 10,
  parameter int STAT_W  = 32,
  parameter int OVF_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_src_live,
  input  logic              cfg_two_pass,
  input  logic              ovf_clr,
  input  logic              live_sof,
  input  logic              live_valid,
  input  logic [DW-1:0]     live_data,
  input  logic              mem_sof,
  input  logic              mem_valid,
  input  logic [DW-1:0]     mem_data,
  input  logic              pass1_done,
  input  logic              pass2_done,
  output logic              rsz_sof,
  output logic              rsz_valid,
  output logic [DW-1:0]     rsz_data,
  output logic              rsz_from_mem,
  output logic              live_ready,
  output logic              ovf_flag,
  output logic [STAT_W-1:0] evt_word
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  logic       late_switch;
  logic       fwd_live;
  logic       fwd_mem;
  logic       ovf_set;
  seq_st_t    st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  rsz_seq_actmon u_act (
    .clk(clk), .rst_n(rst_s_n), .src_live(cfg_src_live),
    .live_sof(live_sof), .live_valid(live_valid), .late_switch(late_switch)
  );

  rsz_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .src_live(cfg_src_live), .two_pass(cfg_two_pass),
    .late_switch(late_switch), .live_sof(live_sof), .mem_sof(mem_sof),
    .pass1_done(pass1_done), .pass2_done(pass2_done), .st(st),
    .fwd_live(fwd_live), .fwd_mem(fwd_mem), .ovf_set(ovf_set)
  );

  rsz_seq_outreg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_s_n), .fwd_live(fwd_live), .fwd_mem(fwd_mem),
    .live_sof(live_sof), .live_valid(live_valid), .live_data(live_data),
    .mem_sof(mem_sof), .mem_valid(mem_valid), .mem_data(mem_data),
    .rsz_sof(rsz_sof), .rsz_valid(rsz_valid), .rsz_data(rsz_data),
    .rsz_from_mem(rsz_from_mem)
  );

  rsz_seq_flag #(.STAT_W(STAT_W), .OVF_BIT(OVF_BIT)) u_flag (
    .clk(clk), .rst_n(rst_s_n), .ovf_set(ovf_set), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag), .evt_word(evt_word)
  );

  assign live_ready = (st == ST_IDLE);
endmodule

// File: rtl/rsz_pass_seq_chk.sv
module rsz_pass_seq_chk
  import rsz_seq_pkg::*;
#(
  parameter int STAT_W  = 32,
  parameter int OVF_BIT = 24
) (
  input logic              clk,
  input logic              rst_s_n,
  input seq_st_t           st,
  input logic              cfg_two_pass,
  input logic              ovf_clr,
  input logic              live_sof,
  input logic              live_valid,
  input logic              mem_valid,
  input logic              pass1_done,
  input logic              rsz_valid,
  input logic              rsz_from_mem,
  input logic              live_ready,
  input logic              ovf_flag,
  input logic [STAT_W-1:0] evt_word
);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(ovf_flag) |-> $past(ovf_clr));

  assert_busy_sof_flags_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((st == ST_WAIT) || (st == ST_P2)) && live_sof |=> ovf_flag);

  assert_no_live_in_wait_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st == ST_WAIT) |=> !(rsz_valid && !rsz_from_mem));

  assert_single_pass_ready_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st == ST_P1) && pass1_done && !cfg_two_pass |=> live_ready);

  assert_evt_onehot_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(evt_word) && (ovf_flag == (evt_word != '0)));

  assert_live_origin_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsz_valid && !rsz_from_mem |-> $past(live_valid));

  assert_mem_origin_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsz_valid && rsz_from_mem |-> $past(mem_valid));
endmodule

bind rsz_pass_seq rsz_pass_seq_chk #(.STAT_W(STAT_W), .OVF_BIT(OVF_BIT)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .st(st), .cfg_two_pass(cfg_two_pass),
  .ovf_clr(ovf_clr), .live_sof(live_sof), .live_valid(live_valid),
  .mem_valid(mem_valid), .pass1_done(pass1_done), .rsz_valid(rsz_valid),
  .rsz_from_mem(rsz_from_mem), .live_ready(live_ready), .ovf_flag(ovf_flag),
  .evt_word(evt_word)
);

// File: tb/sim_rsz_pass_seq.sv
`timescale 1ns/1ps
module sim_rsz_pass_seq;
  localparam int DW = 10;
  localparam int SW = 32;
  localparam int OB = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_src_live = 1'b1, cfg_two_pass = 1'b0, ovf_clr = 1'b0;
  logic live_sof = 1'b0, live_valid = 1'b0, mem_sof = 1'b0, mem_valid = 1'b0;
  logic [DW-1:0] live_data = '0, mem_data = '0;
  logic pass1_done = 1'b0, pass2_done = 1'b0;
  logic rsz_sof, rsz_valid, rsz_from_mem, live_ready, ovf_flag;
  logic [DW-1:0] rsz_data;
  logic [SW-1:0] evt_word;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rsz_pass_seq #(.DW(DW), .STAT_W(SW), .OVF_BIT(OB)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_src_live(cfg_src_live), .cfg_two_pass(cfg_two_pass),
    .ovf_clr(ovf_clr), .live_sof(live_sof), .live_valid(live_valid), .live_data(live_data),
    .mem_sof(mem_sof), .mem_valid(mem_valid), .mem_data(mem_data),
    .pass1_done(pass1_done), .pass2_done(pass2_done), .rsz_sof(rsz_sof),
    .rsz_valid(rsz_valid), .rsz_data(rsz_data), .rsz_from_mem(rsz_from_mem),
    .live_ready(live_ready), .ovf_flag(ovf_flag), .evt_word(evt_word)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply inputs for one cycle, then land on the next falling edge
  task automatic step(input logic ls, input logic lv, input int ld,
                      input logic ms, input logic mv, input int md,
                      input logic p1, input logic p2, input logic clr);
    live_sof = ls; live_valid = lv; live_data = DW'(ld);
    mem_sof = ms;  mem_valid = mv;  mem_data = DW'(md);
    pass1_done = p1; pass2_done = p2; ovf_clr = clr;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic flag_is(input string tag, input bit f);
    chk({tag, " flag"}, ovf_flag, f);
    chk("R9 evt_word", evt_word, f ? (longint'(1) << OB) : 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 ready", live_ready, 1);
    chk("R1 valid", rsz_valid, 0);
    flag_is("R1", 0);

    // R11: pixels with no frame start are not forwarded
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 5 + i, 0, 0, 0, 0, 0, 0);
      chk("R11 no sof", rsz_valid, 0);
    end

    for (int tp = 0; tp < 2; tp++) begin
      for (int n = 1; n <= 4; n++) begin
        cfg_two_pass = tp[0];
        for (int i = 0; i < n; i++) begin
          int d;
          d = (tp * 37 + n * 11 + i * 5) & 10'h3ff;
          step(i == 0, 1, d, 0, 0, 0, 0, 0, 0);
          chk("R2 valid", rsz_valid, 1);
          chk("R2 sof", rsz_sof, i == 0);
          chk("R2 src", rsz_from_mem, 0);
          chk("R2 data", rsz_data, d);
        end
        idle();
        chk("R2 gap", rsz_valid, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0);
        if (tp == 0) begin
          chk("R3 ready", live_ready, 1);
        end else begin
          chk("R4 hold", live_ready, 0);
          step(1, 1, 99, 0, 0, 0, 0, 0, 0);
          chk("R5 drop", rsz_valid, 0);
          flag_is("R5", 1);
          step(0, 1, 98, 0, 0, 0, 0, 0, 1);
          flag_is("R8 clear", 0);
          chk("R5 drop tail", rsz_valid, 0);
          for (int i = 0; i < n; i++) begin
            int d;
            d = (300 + n * 13 + i * 7) & 10'h3ff;
            step(0, 0, 0, i == 0, 1, d, 0, 0, 0);
            chk("R4 valid", rsz_valid, 1);
            chk("R4 src", rsz_from_mem, 1);
            chk("R4 data", rsz_data, d);
          end
          step(1, 1, 77, 0, 0, 0, 0, 0, 0);
          flag_is("R5 in pass2", 1);
          chk("R5 no live", rsz_valid, 0);
          step(0, 0, 0, 0, 0, 0, 0, 1, 1);
          chk("R4 ready", live_ready, 1);
          flag_is("R8 clear2", 0);
        end
      end
    end

    // R6 + R8: late switch to live, clear in the same cycle loses
    cfg_two_pass = 1'b0;
    cfg_src_live = 1'b0; idle();
    cfg_src_live = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    flag_is("R8 set wins", 1);
    chk("R6 not ready", live_ready, 0);
    step(0, 1, 12, 0, 0, 0, 0, 0, 0);
    chk("R6 discard", rsz_valid, 0);
    step(1, 1, 321, 0, 0, 0, 0, 0, 0);
    chk("R6 accept", rsz_valid, 1);
    chk("R6 data", rsz_data, 321);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R6 ready", live_ready, 1);
    flag_is("R6 cleared", 0);

    // R7: switch together with a frame start
    cfg_src_live = 1'b0; idle();
    cfg_src_live = 1'b1;
    step(1, 1, 200, 0, 0, 0, 0, 0, 0);
    flag_is("R7", 0);
    chk("R7 accept", rsz_valid, 1);
    chk("R7 data", rsz_data, 200);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 ready", live_ready, 1);

    // R10 / R11: memory select
    cfg_src_live = 1'b0;
    step(1, 1, 55, 0, 0, 0, 0, 0, 0);
    chk("R11 mem select", rsz_valid, 0);
    chk("R11 ready", live_ready, 1);
    flag_is("R11", 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, i == 0, 1, 400 + i * 9, 0, 0, 0);
      chk("R10 valid", rsz_valid, 1);
      chk("R10 src", rsz_from_mem, 1);
      chk("R10 data", rsz_data, 400 + i * 9);
      chk("R10 busy", live_ready, 0);
    end
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R10 ready", live_ready, 1);

    idle();
    summary();
  end
endmodule